// File: doc/BRIEF.md
# RMII Receive Recovery (MAC side)

This block is the receive front end a MAC places behind a reduced media-independent interface. On every edge of the shared reference clock it can take one 2-bit symbol from the receive data pins together with the combined carrier/data-valid line. It turns the symbol stream into bytes that come with a one-cycle strobe. From the single combined line it recovers two separate indications: carrier sense and receive data valid.

When the combined line rises, the physical layer may send all-zero symbols before real decoding begins. These are dropped, and the byte stream starts at the first nonzero symbol. Symbol pairs from that point on form nibbles. Carrier loss can only be signalled on the first symbol of a nibble. When the carrier ends while buffered data is still pending, the line alternates: low on the first symbol of each nibble and high on the second. The block watches for this pattern so that carrier sense drops at once while data valid stays up until a whole nibble shows the line low.

A speed input selects full-rate sampling, with one symbol per clock at 100 Mb/s, or one sample every tenth clock at 10 Mb/s. In the slower mode the sample point is set near the middle of each symbol's hold window.

Top module: `rmii_rx_recover`

## Requirements
- R1: With `speed_100`=1 one symbol is taken per clock. Symbols are packed least significant first: the first symbol is bits [1:0] and the fourth is bits [7:6]. `byte_valid` is a one-clock pulse in the clock after the fourth symbol is sampled, and `rx_byte` holds the assembled byte in that cycle.
- R2: After `cs_valid_in` rises, symbols equal to 2'b00 are discarded. The first nonzero symbol becomes bits [1:0] of the first byte, and `data_valid` rises one clock after that symbol is sampled.
- R3: `carrier_sense` rises one clock after the first sample with `cs_valid_in` high. It falls one clock after the first sample that lands on a nibble's first symbol with `cs_valid_in` low.
- R4: `data_valid` falls only after `cs_valid_in` is sampled low on both symbols of one nibble. A byte left partly assembled at that point is discarded and gives no `byte_valid`.
- R5: While `cs_valid_in` is low on first symbols and high on second symbols, reception goes on: `data_valid` stays high and every complete byte is delivered.
- R6: If `cs_valid_in` stays high and every symbol is 2'b00 (false carrier), `carrier_sense` stays high for the whole event and `data_valid` and `byte_valid` stay low. The event ends on the first sample with `cs_valid_in` low.
- R7: With `speed_100`=0 one sample is taken every 10 clocks. The first sample falls on the 6th consecutive clock edge at which `cs_valid_in` is high after idle, and later samples follow every 10 clocks.
- R8: If `rx_err_in` is high on any sample of a byte's four symbols, `byte_err` is high together with that byte's `byte_valid`. Otherwise it is low.
- R9: After reset `carrier_sense`, `data_valid`, `byte_valid` and `byte_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1: 100 Mb/s sampling, 0: 10 Mb/s sampling |
| cs_valid_in | input | 1 | Combined carrier / data-valid line |
| rx_dibit | input | 2 | Receive symbol |
| rx_err_in | input | 1 | Receive error marker |
| carrier_sense | output | 1 | Recovered carrier sense |
| data_valid | output | 1 | Recovered receive data valid |
| rx_byte | output | 8 | Assembled byte, meaningful with byte_valid |
| byte_valid | output | 1 | One-clock byte strobe |
| byte_err | output | 1 | Error flag for the byte being strobed |

## Verification
The main function is exercised with several frame shapes. A frame with leading zero symbols and steady carrier tests zero stripping and packing order. A frame whose carrier drops three nibbles early shows whether data valid is kept apart from carrier sense. An all-zero false carrier must raise carrier sense alone, and a frame that stops mid-byte must lose its partial byte. Repeating a frame at 10 Mb/s tests the sample spacing and the mid-window sample point. A single errored symbol must flag exactly the byte that contains it.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int SYM_W       = 2;
  localparam int OCTET_W     = 8;
  localparam int SYM_PER_OCT = OCTET_W / SYM_W;

  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_WAIT = 2'd1,
    LINK_DATA = 2'd2
  } link_state_e;

  // A symbol carries payload once it is nonzero (zeros precede decoding).
  function automatic logic sym_is_payload(input logic [SYM_W-1:0] s);
    return s != '0;
  endfunction

  // Wrapping divider count.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v == lim - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler #(
  parameter int SLOW_DIV = 10,
  parameter int SLOW_MID = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  input  logic line_hi,
  input  logic busy,
  output logic smp
);
  import rmii_rx_pkg::*;
  localparam int CNT_W = $clog2(SLOW_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic             hold_zero;

  assign hold_zero = !busy && !line_hi;
  assign smp       = speed_100 ? 1'b1 : (cnt_q == CNT_W'(SLOW_MID));

  always_ff @(posedge clk) begin
    if (!rst_n || hold_zero) cnt_q <= '0;
    else                     cnt_q <= CNT_W'(wrap_inc(int'(cnt_q), SLOW_DIV));
  end

  assert_slow_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_100 && smp) |=> !smp);
endmodule

// File: rtl/rmii_rx_split.sv
module rmii_rx_split (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp,
  input  logic       cs_valid_in,
  input  logic [1:0] rx_dibit,
  output logic       carrier_sense,
  output logic       data_valid,
  output logic       busy,
  output logic       ev_first,
  output logic       ev_second,
  output logic       ev_drop
);
  import rmii_rx_pkg::*;

  link_state_e st_q;
  logic        ph_q;      // 0: next data sample is a nibble's first symbol
  logic        low_q;     // line was low on this nibble's first symbol
  logic        payload;
  logic        starting;
  logic        in_data;

  assign payload  = sym_is_payload(rx_dibit);
  assign in_data  = (st_q == LINK_DATA);
  assign starting = smp && !in_data && (st_q == LINK_IDLE || st_q == LINK_WAIT)
                    && cs_valid_in && payload;
  assign ev_first  = starting || (smp && in_data && !ph_q);
  assign ev_drop   = smp && in_data && ph_q && low_q && !cs_valid_in;
  assign ev_second = smp && in_data && ph_q && !ev_drop;
  assign busy      = (st_q != LINK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= LINK_IDLE;
      ph_q          <= 1'b0;
      low_q         <= 1'b0;
      carrier_sense <= 1'b0;
      data_valid    <= 1'b0;
    end else if (smp) begin
      unique case (st_q)
        LINK_IDLE, LINK_WAIT: begin
          if (!cs_valid_in) begin
            st_q          <= LINK_IDLE;
            carrier_sense <= 1'b0;
          end else begin
            carrier_sense <= 1'b1;
            if (payload) begin
              st_q       <= LINK_DATA;
              data_valid <= 1'b1;
              ph_q       <= 1'b1;
              low_q      <= 1'b0;
            end else begin
              st_q <= LINK_WAIT;
            end
          end
        end
        LINK_DATA: begin
          if (!ph_q) begin
            ph_q  <= 1'b1;
            low_q <= !cs_valid_in;
            if (!cs_valid_in) carrier_sense <= 1'b0;
          end else begin
            ph_q <= 1'b0;
            if (ev_drop) begin
              st_q          <= LINK_IDLE;
              data_valid    <= 1'b0;
              carrier_sense <= 1'b0;
            end
          end
        end
        default: st_q <= LINK_IDLE;
      endcase
    end
  end

  assert_crs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_sense) |-> $past(cs_valid_in));
  assert_dv_rise_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(rx_dibit != 2'b00));
  assert_dv_fall_line_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> ($past(!cs_valid_in) && !carrier_sense));
  assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_first, ev_second, ev_drop}));
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
  parameter int SYM_W   = 2,
  parameter int OCTET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_first,
  input  logic               ev_second,
  input  logic               ev_drop,
  input  logic [SYM_W-1:0]   rx_dibit,
  input  logic               rx_err_in,
  output logic [OCTET_W-1:0] rx_byte,
  output logic               byte_valid,
  output logic               byte_err
);
  localparam int NIB_W = 2 * SYM_W;

  logic [SYM_W-1:0] held_q;
  logic [NIB_W-1:0] low_nib_q;
  logic             half_q;
  logic             err_q;
  logic [NIB_W-1:0] cur_nib;
  logic             err_now;

  assign cur_nib = {rx_dibit, held_q};
  assign err_now = err_q || rx_err_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= '0;
      low_nib_q  <= '0;
      half_q     <= 1'b0;
      err_q      <= 1'b0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      byte_err   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_err   <= 1'b0;
      if (ev_drop) begin
        half_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (ev_first) begin
        held_q <= rx_dibit;
        err_q  <= err_now;
      end else if (ev_second) begin
        if (!half_q) begin
          low_nib_q <= cur_nib;
          half_q    <= 1'b1;
          err_q     <= err_now;
        end else begin
          rx_byte    <= {cur_nib, low_nib_q};
          byte_valid <= 1'b1;
          byte_err   <= err_now;
          half_q     <= 1'b0;
          err_q      <= 1'b0;
        end
      end
    end
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  assert_err_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_err |-> byte_valid);
endmodule

// File: rtl/rmii_rx_recover.sv
module rmii_rx_recover #(
  parameter int SLOW_DIV = 10,
  parameter int SLOW_MID = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic       cs_valid_in,
  input  logic [1:0] rx_dibit,
  input  logic       rx_err_in,
  output logic       carrier_sense,
  output logic       data_valid,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       byte_err
);
  import rmii_rx_pkg::*;

  logic smp, busy, ev_first, ev_second, ev_drop;

  rmii_rx_sampler #(.SLOW_DIV(SLOW_DIV), .SLOW_MID(SLOW_MID)) u_smp (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
    .line_hi(cs_valid_in), .busy(busy), .smp(smp));

  rmii_rx_split u_split (
    .clk(clk), .rst_n(rst_n), .smp(smp), .cs_valid_in(cs_valid_in),
    .rx_dibit(rx_dibit), .carrier_sense(carrier_sense), .data_valid(data_valid),
    .busy(busy), .ev_first(ev_first), .ev_second(ev_second), .ev_drop(ev_drop));

  rmii_rx_packer #(.SYM_W(SYM_W), .OCTET_W(OCTET_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .ev_first(ev_first), .ev_second(ev_second),
    .ev_drop(ev_drop), .rx_dibit(rx_dibit), .rx_err_in(rx_err_in),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .byte_err(byte_err));

  assert_strobe_inside_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> data_valid);
endmodule

// File: tb/sim_rmii_rx_recover.sv
`timescale 1ns/1ps
module sim_rmii_rx_recover;
  logic clk = 1'b0, rst_n = 1'b0;
  logic speed_100 = 1'b1, cs_valid_in = 1'b0, rx_err_in = 1'b0;
  logic [1:0] rx_dibit = 2'b00;
  logic carrier_sense, data_valid, byte_valid, byte_err;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rmii_rx_recover u0 (.clk(clk), .rst_n(rst_n), .speed_100(speed_100),
    .cs_valid_in(cs_valid_in), .rx_dibit(rx_dibit), .rx_err_in(rx_err_in),
    .carrier_sense(carrier_sense), .data_valid(data_valid), .rx_byte(rx_byte),
    .byte_valid(byte_valid), .byte_err(byte_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_tick;          // clocks elapsed in the current slow symbol slot
  int  m_mode;          // 0 idle, 1 carrier without data, 2 data
  bit  m_second;        // next data sample is a second symbol
  bit  m_first_low;
  int  m_pend;
  bit  m_err;
  int  m_syms[$];
  bit  e_crs, e_dv, e_bv, e_err;
  int  e_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_mode = 0; m_second = 0; m_first_low = 0; m_pend = 0;
      m_err = 0; m_syms.delete(); e_crs = 0; e_dv = 0; e_bv = 0; e_err = 0;
    end else begin
      bit take;
      take = speed_100 || (m_tick == 5);
      m_tick = (m_mode == 0 && !cs_valid_in) ? 0 : (m_tick + 1) % 10;
      e_bv = 0; e_err = 0;
      if (take) begin
        if (m_mode != 2) begin
          if (!cs_valid_in) begin m_mode = 0; e_crs = 0; end
          else begin
            e_crs = 1;
            if (rx_dibit != 0) begin
              m_mode = 2; e_dv = 1; m_second = 1; m_first_low = 0;
              m_pend = rx_dibit; m_err = m_err | rx_err_in;
            end else m_mode = 1;
          end
        end else if (!m_second) begin
          m_second = 1; m_first_low = !cs_valid_in;
          if (!cs_valid_in) e_crs = 0;
          m_pend = rx_dibit; m_err = m_err | rx_err_in;
        end else begin
          m_second = 0;
          if (m_first_low && !cs_valid_in) begin
            m_mode = 0; e_dv = 0; e_crs = 0; m_syms.delete(); m_err = 0;
          end else begin
            m_syms.push_back(m_pend); m_syms.push_back(rx_dibit);
            m_err = m_err | rx_err_in;
            if (m_syms.size() == 4) begin
              e_byte = m_syms[0] + 4*m_syms[1] + 16*m_syms[2] + 64*m_syms[3];
              e_bv = 1; e_err = m_err; m_err = 0; m_syms.delete();
            end
          end
        end
      end
    end
  end

  logic [7:0] got[$];
  bit         got_err[$];

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R3 carrier_sense", carrier_sense, e_crs);
      check("R4 data_valid", data_valid, e_dv);
      check("R1 byte_valid", byte_valid, e_bv);
      if (e_bv && byte_valid) begin
        check("R1 rx_byte", rx_byte, e_byte);
        check("R8 byte_err", byte_err, e_err);
      end
      if (byte_valid) begin got.push_back(rx_byte); got_err.push_back(byte_err); end
    end
    if (cycles > 100000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] frm[$];
  int hold;

  task automatic sym(input bit line, input logic [1:0] s, input bit er);
    repeat (hold) begin
      cs_valid_in = line; rx_dibit = s; rx_err_in = er;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input bit fast, input int lead, input int tail_nib,
                            input int extra_nib, input int err_idx);
    int n;
    logic [1:0] s;
    hold = fast ? 1 : 10;
    speed_100 = fast;
    got.delete(); got_err.delete();
    for (int i = 0; i < lead; i++) sym(1, 2'b00, 0);
    n = frm.size() * 4 + extra_nib * 2;
    for (int i = 0; i < n; i++) begin
      bit line;
      s = (i < frm.size() * 4) ? frm[i/4][2*(i%4) +: 2] : 2'b11;
      line = (i >= n - tail_nib * 2) ? (i % 2 == 1) : 1'b1;
      sym(line, s, i == err_idx);
    end
    sym(0, 2'b00, 0); sym(0, 2'b00, 0);
    repeat (3) sym(0, 2'b00, 0);
  endtask

  task automatic check_bytes(input string req);
    check({req, " byte count"}, got.size(), frm.size());
    for (int i = 0; i < frm.size() && i < got.size(); i++)
      check({req, " byte value"}, got[i], frm[i]);
  endtask

  initial begin
    hold = 1;
    repeat (4) @(negedge clk);
    check("R9 reset carrier_sense", carrier_sense, 0);
    check("R9 reset data_valid", data_valid, 0);
    check("R9 reset byte_valid", byte_valid, 0);
    check("R9 reset byte_err", byte_err, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2: leading zeros then steady carrier
    frm = '{8'h55, 8'h55, 8'hD5, 8'hA7, 8'h3C};
    send_frame(1, 3, 0, 0, -1);
    check_bytes("R2 zero strip");

    // R5: carrier ends three nibbles before the data does
    frm = '{8'h55, 8'hD5, 8'h12, 8'hF0};
    send_frame(1, 0, 3, 0, -1);
    check_bytes("R5 early carrier end");

    // R6: false carrier
    hold = 1; speed_100 = 1; got.delete();
    for (int i = 0; i < 12; i++) sym(1, 2'b00, 0);
    check("R6 crs during false carrier", carrier_sense, 1);
    check("R6 dv during false carrier", data_valid, 0);
    sym(0, 2'b00, 0);
    check("R6 crs after false carrier", carrier_sense, 0);
    check("R6 no bytes", got.size(), 0);
    repeat (3) sym(0, 2'b00, 0);

    // R8: error on the third symbol of byte 2
    frm = '{8'h55, 8'hD5, 8'h81};
    send_frame(1, 1, 0, 0, 10);
    check_bytes("R8 error frame");
    if (got_err.size() == 3) begin
      check("R8 err byte0", got_err[0], 0);
      check("R8 err byte1", got_err[1], 0);
      check("R8 err byte2", got_err[2], 1);
    end

    // R4: frame ends with one extra nibble; partial byte is dropped
    frm = '{8'h55, 8'hD5};
    send_frame(1, 2, 0, 1, -1);
    check_bytes("R4 partial drop");

    // R7: slow mode with an early carrier end
    frm = '{8'h55, 8'hD5, 8'h9E};
    send_frame(0, 2, 2, 0, -1);
    check_bytes("R7 slow frame");

    // R7: slow-mode false carrier
    hold = 10; got.delete();
    for (int i = 0; i < 4; i++) sym(1, 2'b00, 0);
    check("R7 slow false carrier crs", carrier_sense, 1);
    sym(0, 2'b00, 0);
    check("R7 slow false carrier end", carrier_sense, 0);
    check("R7 slow no bytes", got.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule